// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a general-purpose I/O port with a register width set at build time. The pin count always equals that width. It sits on a plain synchronous register bus. A write is taken in the cycle `bus_wr` is high. A read is taken in the cycle `bus_rd` is high, and its data shows on `bus_rdata` one clock later. Every access finishes in a single cycle, so the bus has no handshake and no back-pressure. A pad-side block takes `pad_out` and `pad_oe` for each pin and returns the pad level on `pad_in`. The port samples `pad_in` through a two-flop synchronizer.

Three build-time choices change how the registers behave:
- How the output latch is written. There are three styles: one data register that loads the whole latch, a set register alone that replaces the latch, or a set/clear pair in which each write changes only the bits that are 1.
- Whether a direction register exists, and if so which polarity a 1 has in it.
- Whether pin numbering is bit-reversed, byte-swapped on the bus, or both.

Register offsets on the 4-bit address: 0x0 data, 0x4 set, 0x8 clear, 0xC direction.

Top module: `gpio_sc_port`

## Requirements
- R1: After reset the output latch is all zeros. When a direction register exists, every `pad_oe` bit is 0 (all pins are inputs). The direction register then reads 0 in output polarity and all ones in input polarity.
- R2: A data-register read (0x0) returns the pad levels after a two-flop synchronizer. A pad change made just before a clock edge is not yet visible to a read sampled at the second edge after it. A read sampled later shows the change. Read data appears on `bus_rdata` the cycle after `bus_rd`.
- R3: In single-data-register style (OUT_STYLE = OUT_DATA), a write to 0x0 loads the whole output latch. `pad_out` shows the new value from the next cycle.
- R4: In set/clear style, writing 1 to a bit of the set register (0x4) drives that pin high. Bits written as 0 are left unchanged.
- R5: In set/clear style, writing 1 to a bit of the clear register (0x8) drives that pin low. Bits written as 0 are left unchanged.
- R6: In set-only style, a write to 0x4 replaces every bit of the output latch. That style has no clear register, so writes to 0x8 are ignored.
- R7: In either set style, reading 0x4 returns the output latch. The clear register always reads zero.
- R8: In output polarity (DIR_HIGH_IS_OUT), a 1 in the direction register (0xC) sets `pad_oe` for that pin. The register reads back the value written.
- R9: In input polarity (DIR_HIGH_IS_IN), a 1 in the direction register makes that pin an input, so `pad_oe` is the inverse of the value written.
- R10: With no direction register (DIR_NONE), every `pad_oe` bit stays 1 so each pin drives its latch while its level is still read back. Writes to 0xC are ignored and reads of 0xC return zero.
- R11: With BIT_REV set, pin n corresponds to register bit WIDTH-1-n in every register. For example, with WIDTH 32 and no byte swap, pin 0 is bus bit 31.
- R12: With BYTE_SWAP set, bus byte k carries register byte WIDTH/8-1-k. Combined with BIT_REV at width 32, pin 0 is bus bit 7 and bus bit 0 is pin 7. WIDTH must be 8, 16, 32 or 64, and a byte swap at width 64 is rejected at elaboration.
- R13: Writes to a register the build does not have, or to any other offset, change nothing. This includes the data register in either set style. Reads from such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | WIDTH | Write data in bus bit order |
| bus_rdata | output | WIDTH | Read data, valid the cycle after `bus_rd`, held until the next read |
| pad_in | input | WIDTH | Pad levels, asynchronous to `clk` |
| pad_out | output | WIDTH | Output latch, one bit per pin |
| pad_oe | output | WIDTH | Output enable, one bit per pin |

## Verification
The bench builds three instances that together cover all three write styles, both direction polarities, the case with no direction register, and the combined bit-reversal and byte-swap view. It checks that set and clear writes leave zero bits alone; a design that wrote the set value straight into the latch would drop pins that were already high. It checks that writes to missing registers, and to the data register in set styles, are ignored; a loose decoder would corrupt the latch or the enables. It reads an asymmetric pin pattern through the reversed and swapped view, where a missing or doubled mapping moves the bit to a different lane. It also times the synchronizer: a design with only one flop would show a pad change one read too early.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  // Output-latch write style
  typedef enum logic [1:0] {
    OUT_DATA      = 2'd0,
    OUT_SET_ONLY  = 2'd1,
    OUT_SET_CLEAR = 2'd2
  } out_style_e;

  // Direction register presence and polarity
  typedef enum logic [1:0] {
    DIR_NONE        = 2'd0,
    DIR_HIGH_IS_OUT = 2'd1,
    DIR_HIGH_IS_IN  = 2'd2
  } dir_style_e;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_SET   = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_CLEAR = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 4'hC;

endpackage

// File: rtl/gpio_lane_map.sv
// Maps between pin order and bus bit order. Bit reversal and byte swap
// are each their own inverse and commute, so one instance type serves
// both directions.
module gpio_lane_map #(
  parameter int WIDTH     = 32,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst
);

  localparam int NBYTES = WIDTH / 8;

  logic [WIDTH-1:0] rev;

  if (BIT_REV) begin : g_rev
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign rev[i] = src[WIDTH-1-i];
    end
  end else begin : g_norev
    assign rev = src;
  end

  if (BYTE_SWAP && (NBYTES > 1)) begin : g_swap
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign dst[b*8 +: 8] = rev[(NBYTES-1-b)*8 +: 8];
    end
  end else begin : g_noswap
    assign dst = rev;
  end

endmodule

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the pad inputs.
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] synced
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= pad_in;
      stage2_q <= stage1_q;
    end
  end

  assign synced = stage2_q;

  // Edges seen since reset, saturating at 2, so the delay check never
  // looks back into reset.
  logic [1:0] settle_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              settle_q <= 2'd0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  // R2
  sync_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q == 2'd2) |-> (synced == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_out_regs.sv
// Output latch and direction storage; all values here are in pin order.
module gpio_out_regs
  import gpio_sc_pkg::*;
#(
  parameter int         WIDTH     = 32,
  parameter out_style_e OUT_STYLE = OUT_SET_CLEAR,
  parameter dir_style_e DIR_STYLE = DIR_HIGH_IS_OUT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_wr,
  input  logic             set_wr,
  input  logic             clr_wr,
  input  logic             dir_wr,
  input  logic [WIDTH-1:0] wval,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] dir_view
);

  localparam bit SET_REPLACES = (OUT_STYLE == OUT_SET_ONLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (ld_wr) begin
      latch_q <= wval;
    end else if (set_wr) begin
      latch_q <= SET_REPLACES ? wval : (latch_q | wval);
    end else if (clr_wr) begin
      latch_q <= latch_q & ~wval;
    end
  end

  // R13
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_wr || set_wr || clr_wr) |=> $stable(latch_q));

  if (OUT_STYLE == OUT_DATA) begin : g_ld_chk
    // R3
    data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_wr |=> (latch_q == $past(wval)));
  end else if (OUT_STYLE == OUT_SET_ONLY) begin : g_so_chk
    // R6
    set_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> (latch_q == $past(wval)));
  end else begin : g_sc_chk
    // R4
    set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_wr |=> (((latch_q & $past(wval)) == $past(wval)) &&
                  ((latch_q & ~$past(wval)) == ($past(latch_q) & ~$past(wval)))));
    // R5
    clr_andn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> (((latch_q & $past(wval)) == '0) &&
                  ((latch_q & ~$past(wval)) == ($past(latch_q) & ~$past(wval)))));
  end

  if (DIR_STYLE == DIR_NONE) begin : g_nodir
    logic unused_dir;
    assign unused_dir = dir_wr;
    assign oe         = '1;
    assign dir_view   = '0;
  end else begin : g_dir
    localparam bit INV = (DIR_STYLE == DIR_HIGH_IS_IN);
    logic [WIDTH-1:0] dir_q;

    // Reset value means "all pins input" in either polarity.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= INV ? '1 : '0;
      else if (dir_wr) dir_q <= wval;
    end

    assign oe       = INV ? ~dir_q : dir_q;
    assign dir_view = dir_q;

    if (INV) begin : g_inv_chk
      // R9
      dir_in_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (oe == ~$past(wval)));
    end else begin : g_pos_chk
      // R8
      dir_out_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (oe == $past(wval)));
    end
  end

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
  import gpio_sc_pkg::*;
#(
  parameter int         WIDTH     = 32,
  parameter out_style_e OUT_STYLE = OUT_SET_CLEAR,
  parameter dir_style_e DIR_STYLE = DIR_HIGH_IS_OUT,
  parameter bit         BIT_REV   = 1'b0,
  parameter bit         BYTE_SWAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);

  localparam bit HAS_SET   = (OUT_STYLE != OUT_DATA);
  localparam bit HAS_CLEAR = (OUT_STYLE == OUT_SET_CLEAR);
  localparam bit HAS_DIR   = (DIR_STYLE != DIR_NONE);

  // R12: build-time legality
  if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
    $error("gpio_sc_port: WIDTH must be 8, 16, 32 or 64");
  end
  if (BYTE_SWAP && (WIDTH == 64)) begin : g_bad_swap
    $error("gpio_sc_port: byte swap is not available at width 64");
  end

  logic [WIDTH-1:0] wval_pin;
  logic [WIDTH-1:0] synced;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_view;
  logic [WIDTH-1:0] rd_pin;
  logic [WIDTH-1:0] rd_bus;
  logic             addr_hit;
  logic             ld_wr, set_wr, clr_wr, dir_wr;

  gpio_lane_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_wmap (
    .src (bus_wdata),
    .dst (wval_pin)
  );

  gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .synced (synced)
  );

  // Write decode: registers the build does not have are never strobed.
  assign ld_wr  = bus_wr && (bus_addr == OFS_DATA)  && !HAS_SET;
  assign set_wr = bus_wr && (bus_addr == OFS_SET)   && HAS_SET;
  assign clr_wr = bus_wr && (bus_addr == OFS_CLEAR) && HAS_CLEAR;
  assign dir_wr = bus_wr && (bus_addr == OFS_DIR)   && HAS_DIR;

  gpio_out_regs #(.WIDTH(WIDTH), .OUT_STYLE(OUT_STYLE), .DIR_STYLE(DIR_STYLE)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_wr    (ld_wr),
    .set_wr   (set_wr),
    .clr_wr   (clr_wr),
    .dir_wr   (dir_wr),
    .wval     (wval_pin),
    .latch_q  (latch_q),
    .oe       (pad_oe),
    .dir_view (dir_view)
  );

  assign pad_out = latch_q;

  // Read select in pin order
  always_comb begin
    rd_pin   = '0;
    addr_hit = 1'b0;
    unique case (bus_addr)
      OFS_DATA: begin
        rd_pin   = synced;
        addr_hit = 1'b1;
      end
      OFS_SET: begin
        rd_pin   = HAS_SET ? latch_q : '0;
        addr_hit = HAS_SET;
      end
      OFS_DIR: begin
        rd_pin   = HAS_DIR ? dir_view : '0;
        addr_hit = HAS_DIR;
      end
      default: begin
        rd_pin   = '0;
        addr_hit = 1'b0;
      end
    endcase
  end

  gpio_lane_map #(.WIDTH(WIDTH), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_rmap (
    .src (rd_pin),
    .dst (rd_bus)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_bus;
  end

  // R13
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_hit) |=> (bus_rdata == '0));

  // R1
  reset_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_out == '0));

  if (HAS_DIR) begin : g_rst_oe
    // R1
    reset_all_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0));
  end

endmodule

// File: tb/test_gpio_sc_port.sv
module test_gpio_sc_port;
  import gpio_sc_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        wr, rd;
  logic [3:0]  addr;
  logic [63:0] wdata;
  int          sel;

  logic [15:0] pin_a, out_a, oe_a, rdat_a;
  logic [7:0]  pin_b, out_b, oe_b, rdat_b;
  logic [31:0] pin_c, out_c, oe_c, rdat_c;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // A: 16-bit, set/clear pair, high-is-output direction
  gpio_sc_port #(.WIDTH(16), .OUT_STYLE(OUT_SET_CLEAR), .DIR_STYLE(DIR_HIGH_IS_OUT),
                 .BIT_REV(1'b0), .BYTE_SWAP(1'b0)) i_gpio_sc_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr && sel == 0), .bus_rd(rd && sel == 0),
    .bus_addr(addr), .bus_wdata(wdata[15:0]), .bus_rdata(rdat_a),
    .pad_in(pin_a), .pad_out(out_a), .pad_oe(oe_a));

  // B: 8-bit, single data register, high-is-input direction
  gpio_sc_port #(.WIDTH(8), .OUT_STYLE(OUT_DATA), .DIR_STYLE(DIR_HIGH_IS_IN),
                 .BIT_REV(1'b0), .BYTE_SWAP(1'b0)) i_gpio_sc_port_b (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr && sel == 1), .bus_rd(rd && sel == 1),
    .bus_addr(addr), .bus_wdata(wdata[7:0]), .bus_rdata(rdat_b),
    .pad_in(pin_b), .pad_out(out_b), .pad_oe(oe_b));

  // C: 32-bit, set-only, no direction register, reversed and swapped
  gpio_sc_port #(.WIDTH(32), .OUT_STYLE(OUT_SET_ONLY), .DIR_STYLE(DIR_NONE),
                 .BIT_REV(1'b1), .BYTE_SWAP(1'b1)) i_gpio_sc_port_c (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr && sel == 2), .bus_rd(rd && sel == 2),
    .bus_addr(addr), .bus_wdata(wdata[31:0]), .bus_rdata(rdat_c),
    .pad_in(pin_c), .pad_out(out_c), .pad_oe(oe_c));

  typedef struct {
    int          s;
    logic [63:0] e;
    string       r;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reversal then byte swap at width 32 equals reversing bits inside each byte.
  function automatic logic [31:0] bus_to_pins_c(input logic [31:0] v);
    logic [31:0] o;
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 8; i++)
        o[b*8 + 7 - i] = v[b*8 + i];
    return o;
  endfunction

  task automatic wr_reg(input int s, input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    sel = s; addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int s, input logic [3:0] a, input logic [63:0] e,
                        input string req);
    exp_t it;
    @(negedge clk);
    sel = s; addr = a; rd = 1'b1;
    it.s = s; it.e = e; it.r = req;
    exp_q.push_back(it);
    @(negedge clk);
    rd = 1'b0;
  endtask

  // Monitor: pops an expected item for each read the design answered.
  logic rd_d;
  always @(posedge clk) rd_d <= rd;

  always @(negedge clk) begin
    exp_t        it;
    logic [63:0] act;
    if (rd_d === 1'b1) begin
      if (exp_q.size() == 0) begin
        chk(64'd1, 64'd0, "scoreboard underflow");
      end else begin
        it  = exp_q.pop_front();
        act = (it.s == 0) ? {48'd0, rdat_a} :
              (it.s == 1) ? {56'd0, rdat_b} : {32'd0, rdat_c};
        chk(act, it.e, it.r);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; sel = 0;
    pin_a = 16'h0000;
    pin_b = 8'h3C;
    pin_c = 32'h0000_0001;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk({48'd0, out_a}, 64'h0, "R1 latch A");
    chk({48'd0, oe_a},  64'h0, "R1 oe A");
    chk({56'd0, oe_b},  64'h0, "R1 oe B");
    rd_reg(0, OFS_DIR, 64'h0,  "R1 dir A reads 0");
    rd_reg(1, OFS_DIR, 64'hFF, "R1 R9 dir B reads ones");
    // R10: no direction register
    chk({32'd0, oe_c}, 64'hFFFF_FFFF, "R10 oe C all ones");

    // R8: high-is-output polarity
    wr_reg(0, OFS_DIR, 64'h00FF);
    chk({48'd0, oe_a}, 64'h00FF, "R8 oe A");
    rd_reg(0, OFS_DIR, 64'h00FF, "R8 dir readback");

    // R4: set only raises ones
    wr_reg(0, OFS_SET, 64'h0F0F);
    chk({48'd0, out_a}, 64'h0F0F, "R4 set");
    wr_reg(0, OFS_SET, 64'h1000);
    chk({48'd0, out_a}, 64'h1F0F, "R4 zero bits kept");
    // R5: clear only lowers ones
    wr_reg(0, OFS_CLEAR, 64'h0101);
    chk({48'd0, out_a}, 64'h1E0E, "R5 clear");
    // R7: set reads latch, clear reads zero
    rd_reg(0, OFS_SET,   64'h1E0E, "R7 set readback");
    rd_reg(0, OFS_CLEAR, 64'h0,    "R7 clear reads zero");
    // R13: data register not writable in set style, unused offset
    wr_reg(0, OFS_DATA, 64'hFFFF);
    chk({48'd0, out_a}, 64'h1E0E, "R13 data write ignored");
    wr_reg(0, 4'h2, 64'hFFFF);
    chk({48'd0, out_a}, 64'h1E0E, "R13 unused offset write");
    chk({48'd0, oe_a},  64'h00FF, "R13 oe untouched");
    rd_reg(0, 4'h2, 64'h0, "R13 unused offset read");

    // R2: synchronizer delay
    @(negedge clk);
    pin_a = 16'hA5C3;
    rd_reg(0, OFS_DATA, 64'h0000, "R2 not yet visible");
    rd_reg(0, OFS_DATA, 64'hA5C3, "R2 visible");

    // R9: high-is-input polarity
    wr_reg(1, OFS_DIR, 64'hF0);
    chk({56'd0, oe_b}, 64'h0F, "R9 oe B inverted");
    // R3: data register load
    wr_reg(1, OFS_DATA, 64'h5A);
    chk({56'd0, out_b}, 64'h5A, "R3 load");
    wr_reg(1, OFS_DATA, 64'hA1);
    chk({56'd0, out_b}, 64'hA1, "R3 reload");
    // R13: set register absent in data style
    wr_reg(1, OFS_SET, 64'h0F);
    chk({56'd0, out_b}, 64'hA1, "R13 set absent");
    rd_reg(1, OFS_SET,  64'h0,  "R13 set absent read");
    rd_reg(1, OFS_DATA, 64'h3C, "R2 data B");

    // R11 R12: bus bit 0 lands on pin 7
    wr_reg(2, OFS_SET, 64'h0000_0001);
    chk({32'd0, out_c}, {32'd0, bus_to_pins_c(32'h1)}, "R11 R12 write map");
    chk({32'd0, out_c}, 64'h80, "R12 pin 7");
    // R6: set replaces whole latch
    wr_reg(2, OFS_SET, 64'h1234_5678);
    chk({32'd0, out_c}, {32'd0, bus_to_pins_c(32'h1234_5678)}, "R6 replace");
    rd_reg(2, OFS_SET, 64'h1234_5678, "R7 R12 set roundtrip");
    wr_reg(2, OFS_CLEAR, 64'hFFFF_FFFF);
    chk({32'd0, out_c}, {32'd0, bus_to_pins_c(32'h1234_5678)}, "R6 no clear reg");
    // R10: direction offset absent
    wr_reg(2, OFS_DIR, 64'h0);
    chk({32'd0, oe_c}, 64'hFFFF_FFFF, "R10 dir write ignored");
    rd_reg(2, OFS_DIR, 64'h0, "R10 dir reads zero");
    // R11: pin 0 reads as bus bit 7
    rd_reg(2, OFS_DATA, 64'h80, "R11 read map");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 64'd0, "scoreboard drained");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule